// File: doc/BRIEF.md
# Block Mean Accumulator with Ready Semaphore

This block averages a stream of signed fixed-point samples over consecutive, non-overlapping blocks of `BLOCK_N` samples. Each sample comes with a coefficient, normally the reciprocal 1/N. A value of 0x0CCCCC encodes 0.1 in Q1.23. The block multiplies the sample by its coefficient and adds the product to a wide accumulator. It never sums the raw samples on their own, so the accumulator already holds the mean when the block ends.

When the last sample of a block has been accumulated, the block spends one cycle writing the rounded and saturated result to an output holding register. In that cycle it also emits a one-cycle interrupt pulse, sets a sticky flag that software clears, and empties the accumulator and the sample counter.

A one-entry staging register sits in front of the datapath. It holds a sample that arrives during the write cycle so that the sample is not lost. A ready semaphore tells the producer that the block is idle, with nothing staged, and waiting for input.

Top module: `blk_mean_acc`

## Requirements
- R1: After reset, `mean_out` is 0, `irq_pulse` is 0, `irq_flag` is 0 and `ready_sem` is 1.
- R2: Samples and coefficients are signed Q1.23 (24 bits, two's complement). Each accepted sample is multiplied by the coefficient presented with it, and the 48-bit product is added to a 48-bit accumulator.
- R3: After the `BLOCK_N`th sample (default 10), the new `mean_out` is computed in three steps:
  - take the accumulator, add 2^22, and shift it arithmetically right by 23;
  - saturate the result to the range -2^23 .. 2^23-1;
  - hold that value until the next block completes.
  The accumulator and the sample count then restart from zero, so the next block is independent.
- R4: The pipeline timing is fixed by clock edges.
  - A sample with `smp_valid` high at edge k is accumulated at edge k+1.
  - When that sample is the last of its block, `mean_out` and `irq_pulse` change at edge k+2.
  - Samples may stream at one per cycle, with one extra cycle for each block.
- R5: `ready_sem` is high only while the block waits with an empty staging register. It is low in the cycle after a sample is captured.
- R6: `irq_pulse` is high for exactly one cycle for each block result.
- R7: `irq_flag` is set together with `irq_pulse` and stays set until `irq_ack` is high at a clock edge. It is then 0 in the following cycle.
- R8: A sample captured while the block is in its write cycle is held and accumulated as the first sample of the next block.
- R9: A sample presented while the staging register is occupied and is not being drained is discarded. It has no effect on any later result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 24 | Signed Q1.23 sample |
| smp_coef | input | 24 | Signed Q1.23 coefficient for this sample |
| irq_ack | input | 1 | Clears the sticky interrupt flag |
| ready_sem | output | 1 | Block idle and waiting for a sample |
| mean_out | output | 24 | Output holding register, signed Q1.23 |
| irq_pulse | output | 1 | One-cycle result-valid pulse |
| irq_flag | output | 1 | Sticky result-valid flag |

## Verification
The hardest situation to reach is the block boundary under a full-rate stream. There, the write cycle stalls the datapath while one sample sits in staging and a further sample arrives that must be dropped. A producer that waits for `ready_sem` never gets there.

The bench therefore drives `smp_valid` on every cycle for twelve consecutive samples, ignoring the semaphore. The eleventh sample lands in staging during the write cycle, and the twelfth, which has a distinctive large value, collides with it. A paced block then completes. Its result, compared with the mean expected from the held sample alone, shows both that the held sample survived and that the dropped one left no trace. The same stream also pins the exact edge at which the result and the pulse appear.

// File: rtl/bma_pkg.sv
package bma_pkg;
  typedef enum logic {
    ST_WAIT  = 1'b0,
    ST_WRITE = 1'b1
  } bma_state_e;
endpackage

// File: rtl/bma_stage.sv
module bma_stage #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_smp,
  input  logic [DW-1:0] in_coef,
  input  logic          drain,
  output logic          full,
  output logic [DW-1:0] out_smp,
  output logic [DW-1:0] out_coef
);
  logic          full_q, full_d, load;
  logic [DW-1:0] smp_q, coef_q;

  assign load = in_valid && (!full_q || drain);

  always_comb begin
    full_d = full_q;
    if (load)       full_d = 1'b1;
    else if (drain) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= '0;
      coef_q <= '0;
    end else if (load) begin
      smp_q  <= in_smp;
      coef_q <= in_coef;
    end
  end

  assign full     = full_q;
  assign out_smp  = smp_q;
  assign out_coef = coef_q;

  // R9: an occupied, undrained entry is not overwritten by a new arrival
  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && in_valid && !drain) |=> ($stable(out_smp) && $stable(out_coef) && full));
endmodule

// File: rtl/bma_mac.sv
module bma_mac #(
  parameter int DW = 24,
  parameter int AW = 48,
  parameter int N  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clear,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic [AW-1:0] acc,
  output logic          last
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(N - 1);

  logic signed [2*DW-1:0] prod;
  logic signed [AW-1:0]   prod_x;
  logic [AW-1:0]          acc_q, acc_d;
  logic [CW-1:0]          cnt_q, cnt_d;

  assign prod   = $signed(op_a) * $signed(op_b);
  assign prod_x = AW'(prod);
  assign last   = step && (cnt_q == CNT_LAST);

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (clear) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (step) begin
      acc_d = acc_q + AW'(prod_x);
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign acc = acc_q;

  // R3: sample count never leaves 0..N-1
  a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
  // R8: a write-cycle clear never coincides with accumulation
  a_r8_no_step_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear && step));
endmodule

// File: rtl/bma_round.sv
module bma_round #(
  parameter int DW = 24,
  parameter int AW = 48
) (
  input  logic [AW-1:0] acc,
  output logic [DW-1:0] result
);
  localparam int FRAC = DW - 1;
  localparam logic signed [AW:0] RND  = (AW+1)'(1) <<< (FRAC - 1);
  localparam logic signed [AW:0] MAXV = ((AW+1)'(1) <<< (DW - 1)) - (AW+1)'(1);
  localparam logic signed [AW:0] MINV = -((AW+1)'(1) <<< (DW - 1));

  logic signed [AW:0] ext, rnd, shf;

  always_comb begin
    ext = $signed({acc[AW-1], acc});
    rnd = ext + RND;
    shf = rnd >>> FRAC;
    if (shf > MAXV)      result = MAXV[DW-1:0];
    else if (shf < MINV) result = MINV[DW-1:0];
    else                 result = shf[DW-1:0];
  end
endmodule

// File: rtl/blk_mean_acc.sv
module blk_mean_acc #(
  parameter int DW      = 24,
  parameter int AW      = 48,
  parameter int BLOCK_N = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic [DW-1:0] smp_coef,
  input  logic          irq_ack,
  output logic          ready_sem,
  output logic [DW-1:0] mean_out,
  output logic          irq_pulse,
  output logic          irq_flag
);
  import bma_pkg::*;

  bma_state_e    state_q, state_d;
  logic          stage_full, drain, last, writing;
  logic [DW-1:0] st_smp, st_coef, rounded;
  logic [AW-1:0] acc;
  logic [DW-1:0] mean_q;
  logic          pulse_q, flag_q, flag_d;

  assign writing = (state_q == ST_WRITE);
  assign drain   = (state_q == ST_WAIT) && stage_full;

  bma_stage #(.DW(DW)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(smp_valid), .in_smp(smp_data),
    .in_coef(smp_coef), .drain(drain), .full(stage_full),
    .out_smp(st_smp), .out_coef(st_coef)
  );

  bma_mac #(.DW(DW), .AW(AW), .N(BLOCK_N)) u_mac (
    .clk(clk), .rst_n(rst_n), .step(drain), .clear(writing),
    .op_a(st_smp), .op_b(st_coef), .acc(acc), .last(last)
  );

  bma_round #(.DW(DW), .AW(AW)) u_round (
    .acc(acc), .result(rounded)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_WAIT:  if (last) state_d = ST_WRITE;
      ST_WRITE: state_d = ST_WAIT;
      default:  state_d = ST_WAIT;
    endcase
  end

  always_comb begin
    flag_d = flag_q;
    if (writing)      flag_d = 1'b1;
    else if (irq_ack) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= writing;
      flag_q  <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mean_q <= '0;
    else if (writing) mean_q <= rounded;
  end

  assign ready_sem = (state_q == ST_WAIT) && !stage_full;
  assign mean_out  = mean_q;
  assign irq_pulse = pulse_q;
  assign irq_flag  = flag_q;

  // R6: result pulse lasts a single cycle
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  // R7: sticky flag accompanies every pulse
  a_r7_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_flag);
  // R3: holding register changes only with a result pulse
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pulse |-> $stable(mean_out));
  // R3: accumulator is empty after the write cycle
  a_r3_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    writing |=> (acc == '0));
  // R8: a sample staged during the write cycle survives it
  a_r8_stage_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (writing && stage_full) |=> (stage_full && !ready_sem));
endmodule

// File: tb/blk_mean_acc_tb_top.sv
module blk_mean_acc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 10;
  localparam int NVEC = 20;

  // stimulus table: {sample, coefficient}, two blocks
  localparam logic [47:0] VEC [NVEC] = '{
    {24'h100000, 24'h0CCCCC}, {24'h200000, 24'h0CCCCC}, {24'hF00000, 24'h0CCCCC},
    {24'h7FFFFF, 24'h0CCCCC}, {24'h000001, 24'h0CCCCC}, {24'h123456, 24'h0CCCCC},
    {24'hE00000, 24'h0CCCCC}, {24'h050505, 24'h0CCCCC}, {24'h3FFFFF, 24'h0CCCCC},
    {24'h800000, 24'h0CCCCC},
    {24'h400000, 24'h100000}, {24'hC00000, 24'h200000}, {24'h654321, 24'hF80000},
    {24'h0ABCDE, 24'h0CCCCC}, {24'hFFFFFF, 24'h7FFFFF}, {24'h222222, 24'h111111},
    {24'hD00000, 24'hE00000}, {24'h000100, 24'h400000}, {24'h7FFFFF, 24'h7FFFFF},
    {24'h800000, 24'h0CCCCC}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [23:0] smp_data, smp_coef;
  logic        irq_ack;
  logic        ready_sem, irq_pulse, irq_flag;
  logic [23:0] mean_out;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  longint sum;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_mean_acc dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_coef(smp_coef), .irq_ack(irq_ack), .ready_sem(ready_sem),
    .mean_out(mean_out), .irq_pulse(irq_pulse), .irq_flag(irq_flag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic longint sx(input logic [23:0] v);
    return longint'({{40{v[23]}}, v});
  endfunction

  function automatic logic [23:0] model_mean(input longint s);
    longint r;
    r = (s + 64'sd4194304) >>> 23;
    if (r > 64'sd8388607)  r = 64'sd8388607;
    if (r < -64'sd8388608) r = -64'sd8388608;
    return r[23:0];
  endfunction

  task automatic send_paced(input logic [23:0] d, input logic [23:0] c);
    while (!ready_sem) @(negedge clk);
    smp_valid = 1'b1; smp_data = d; smp_coef = c;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_result(input string req, input logic [23:0] exp);
    int k = 0;
    while (!irq_pulse && k < 8) begin @(negedge clk); k++; end
    check(irq_pulse == 1'b1, req, 32'(irq_pulse), 32'd1);
    check(mean_out == exp, req, 32'(mean_out), 32'(exp));
    @(negedge clk);
    check(irq_pulse == 1'b0, "R6", 32'(irq_pulse), 32'd0);  // R6 one-cycle pulse
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; smp_coef = '0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mean_out == 24'd0, "R1", 32'(mean_out), 32'd0);
    check(irq_pulse == 1'b0 && irq_flag == 1'b0, "R1", {30'd0, irq_pulse, irq_flag}, 32'd0);
    check(ready_sem == 1'b1, "R1", 32'(ready_sem), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: table-driven blocks, paced by the semaphore
    sum = 0;
    for (int i = 0; i < NVEC; i++) begin
      send_paced(VEC[i][47:24], VEC[i][23:0]);
      if (i == 0) check(ready_sem == 1'b0, "R5", 32'(ready_sem), 32'd0); // R5
      sum += sx(VEC[i][47:24]) * sx(VEC[i][23:0]);
      if (i % NBLK == NBLK - 1) begin
        wait_result("R2", model_mean(sum));
        sum = 0;
      end
    end
    check(ready_sem == 1'b1, "R5", 32'(ready_sem), 32'd1);

    // R4 R8 R9: full-rate stream across a block boundary
    for (int i = 0; i < 12; i++) begin
      smp_valid = 1'b1;
      smp_coef  = 24'h0CCCCC;
      smp_data  = (i < 10) ? 24'h400000 : ((i == 10) ? 24'h200000 : 24'h7FFFFF);
      @(negedge clk);
      if (i == 10) check(irq_pulse == 1'b0, "R4", 32'(irq_pulse), 32'd0);
      if (i == 11) begin
        check(irq_pulse == 1'b1, "R4", 32'(irq_pulse), 32'd1);
        check(mean_out == 24'h3FFFFC, "R4", 32'(mean_out), 32'h3FFFFC);
      end
    end
    smp_valid = 1'b0;
    @(negedge clk);
    check(irq_pulse == 1'b0, "R6", 32'(irq_pulse), 32'd0);

    // R7 sticky flag holds, then clears on acknowledge
    repeat (3) @(negedge clk);
    check(irq_flag == 1'b1, "R7", 32'(irq_flag), 32'd1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(irq_flag == 1'b0, "R7", 32'(irq_flag), 32'd0);

    // R8 held sample is first of next block; R9 dropped sample leaves no trace
    sum = sx(24'h200000) * sx(24'h0CCCCC);
    for (int i = 0; i < NBLK - 1; i++) begin
      send_paced(24'h200000, 24'h0CCCCC);
      sum += sx(24'h200000) * sx(24'h0CCCCC);
    end
    wait_result("R8_R9", model_mean(sum));
    check(mean_out == 24'h1FFFFE, "R9", 32'(mean_out), 32'h1FFFFE);

    // R3 positive and negative saturation
    for (int i = 0; i < NBLK; i++) send_paced(24'h7FFFFF, 24'h7FFFFF);
    wait_result("R3_sat_pos", 24'h7FFFFF);
    for (int i = 0; i < NBLK; i++) send_paced(24'h800000, 24'h7FFFFF);
    wait_result("R3_sat_neg", 24'h800000);

    // R3 independence: block after saturation starts from zero
    for (int i = 0; i < NBLK; i++) send_paced(24'hC00000, 24'h0CCCCC);
    wait_result("R3_clear", 24'hC00004);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule